// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Idle Parking

This block decides which of five bus masters owns one slave port of a multi-master interconnect. Each master raises a request line while it wants the slave and pulses a burst-end line on the last transfer of its burst. The arbiter answers with a registered one-hot grant, the index of the granted master and a connected flag. A master may transfer in any cycle in which both its request and its grant are high.

When the slave has nothing left to do, the arbiter chooses where it parks. It can drop the connection, stay with the master that used the slave last, or move to a configured master. A master that finds the slave already parked on it transfers with no delay. Every other master waits one extra cycle while the connection is made. A slot limit keeps a slow slave from being held by one very long burst. Once a burst has used up its allowance of transfer cycles, a waiting master takes over.

Configuration arrives on three plain input ports: a slot limit, a parking mode and a fixed master index. Address decoding, data multiplexing and register access live outside this block.

Top module: `slot_arb`

## Requirements
- R1: While reset is high, and on the first clock after it, the grant is all zero, the connected flag is low, the granted index reads 0 and the last-user record is master 0.
- R2: With parking mode 0 or 3, an arbitration point that finds no other request disconnects the slave.
- R3: With parking mode 1, an arbitration point that finds no other request keeps the slave connected to the master that transferred last, or to master 0 if none has transferred since reset.
- R4: With parking mode 2 and a fixed index from 0 to 4, an idle arbitration point connects the slave to that master. A fixed index from 5 to 7 behaves like mode 0.
- R5: A master that is already parked on the slave is granted in the cycle it first requests. Any other master is granted one clock after its request is seen.
- R6: When several masters compete at an arbitration point, the winner is the first requester after the last-user index, searching upward and wrapping from 4 to 0.
- R7: With a slot limit L from 1 to 255, a burst that runs L transfer cycles with no burst end, while another master requests, loses the grant at the end of its L-th transfer cycle.
- R8: With slot limit 0, or with no other master requesting, a burst keeps its grant until its burst-end cycle.
- R9: The grant has at most one bit set. That bit matches the granted index, and the connected flag is high exactly when a bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_MASTERS | Per-master request |
| burst_end_i | input | NUM_MASTERS | Per-master last-transfer marker, valid together with the request |
| cfg_limit_i | input | 8 | Slot limit in transfer cycles, 0 = unlimited |
| cfg_park_i | input | 2 | Parking mode: 0 none, 1 last user, 2 fixed, 3 none |
| cfg_fixed_i | input | 3 | Fixed parking master index, 5 to 7 = none |
| gnt_o | output | NUM_MASTERS | One-hot grant (registered) |
| gnt_idx_o | output | $clog2(NUM_MASTERS) | Index of the connected master |
| connected_o | output | 1 | Slave is connected to some master |

## Verification
The assertions check on every cycle that the grant stays one-hot and agrees with the index and connected flag. They also check the parking result after every idle cycle under each mode, that an unbroken burst keeps its grant, and that an expired slot under contention hands the grant away. The cycle-exact effects are shown only by the bench's sweeps. These include the zero-or-one-cycle connection penalty for each combination of mode, fixed index and requesting master, the full round-robin order from every starting owner, and the exact number of transfer cycles each side gets for several slot limits.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int LIMIT_W = 8;
  localparam int FIXED_W = 3;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;
endpackage

// File: rtl/slot_arb_rr.sv
module slot_arb_rr #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] last_i,
  output logic          hit_o,
  output logic [IW-1:0] pick_o
);
  logic [IW-1:0] probe;

  // Walk from the farthest candidate to the nearest, so the nearest wins.
  always_comb begin
    hit_o  = 1'b0;
    pick_o = last_i;
    probe  = '0;
    for (int k = N; k >= 1; k--) begin
      probe = IW'((int'(last_i) + k) % N);
      if (cand_i[probe]) begin
        hit_o  = 1'b1;
        pick_o = probe;
      end
    end
  end
endmodule

// File: rtl/slot_arb_park.sv
module slot_arb_park
  import slot_arb_pkg::*;
#(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  park_mode_e          mode_i,
  input  logic [FIXED_W-1:0]  fixed_i,
  input  logic [IW-1:0]       last_i,
  output logic                ok_o,
  output logic [IW-1:0]       idx_o
);
  always_comb begin
    ok_o  = 1'b0;
    idx_o = '0;
    case (mode_i)
      PARK_LAST: begin
        ok_o  = 1'b1;
        idx_o = last_i;
      end
      PARK_FIXED: begin
        if (int'(fixed_i) < N) begin
          ok_o  = 1'b1;
          idx_o = IW'(fixed_i);
        end
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/slot_arb_slot.sv
module slot_arb_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      used_q <= '0;
    else if (tick_i && (used_q != {W{1'b1}}))
      used_q <= used_q + 1'b1;
  end

  // The current cycle is the L-th transfer of the burst.
  assign expired_o = (limit_i != '0) && (used_q >= (limit_i - W'(1)));
endmodule

// File: rtl/slot_arb.sv
module slot_arb
  import slot_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  localparam int IW = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] burst_end_i,
  input  logic [LIMIT_W-1:0]     cfg_limit_i,
  input  logic [1:0]             cfg_park_i,
  input  logic [FIXED_W-1:0]     cfg_fixed_i,
  output logic [NUM_MASTERS-1:0] gnt_o,
  output logic [IW-1:0]          gnt_idx_o,
  output logic                   connected_o
);
  localparam int N = NUM_MASTERS;

  logic          conn_q, conn_n;
  logic [IW-1:0] own_q, own_n;
  logic [IW-1:0] last_q, last_n, last_eff;
  logic [N-1:0]  gnt_q, gnt_n;
  logic [N-1:0]  own_mask, others;
  logic          xfer, cont, brk, arb_pt, expired;
  logic          rr_hit, pk_ok;
  logic [IW-1:0] rr_pick, pk_idx;
  park_mode_e    mode;

  assign mode     = park_mode_e'(cfg_park_i);
  assign xfer     = conn_q && req_i[own_q];
  assign cont     = xfer && !burst_end_i[own_q];
  assign own_mask = conn_q ? (N'(1) << own_q) : '0;
  assign others   = req_i & ~own_mask;
  assign brk      = cont && expired && (|others);
  assign arb_pt   = !cont || brk;
  assign last_eff = xfer ? own_q : last_q;

  slot_arb_rr #(.N(N)) u_rr (
    .cand_i (others),
    .last_i (last_eff),
    .hit_o  (rr_hit),
    .pick_o (rr_pick)
  );

  slot_arb_park #(.N(N)) u_park (
    .mode_i  (mode),
    .fixed_i (cfg_fixed_i),
    .last_i  (last_eff),
    .ok_o    (pk_ok),
    .idx_o   (pk_idx)
  );

  slot_arb_slot #(.W(LIMIT_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .restart_i (arb_pt),
    .tick_i    (xfer),
    .limit_i   (cfg_limit_i),
    .expired_o (expired)
  );

  always_comb begin
    conn_n = conn_q;
    own_n  = own_q;
    if (arb_pt) begin
      if (rr_hit) begin
        conn_n = 1'b1;
        own_n  = rr_pick;
      end else if (pk_ok) begin
        conn_n = 1'b1;
        own_n  = pk_idx;
      end else begin
        conn_n = 1'b0;
      end
    end
    last_n = (arb_pt && rr_hit) ? rr_pick : last_eff;
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign gnt_n[i] = conn_n && (own_n == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      own_q  <= '0;
      last_q <= '0;
      gnt_q  <= '0;
    end else begin
      conn_q <= conn_n;
      own_q  <= own_n;
      last_q <= last_n;
      gnt_q  <= gnt_n;
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_idx_o   = own_q;
  assign connected_o = conn_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (gnt_o == '0 && !connected_o && gnt_idx_o == '0 && last_q == '0));

  assert_grant_shape_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o) && (connected_o == (gnt_o != '0)) &&
    (!connected_o || gnt_o[gnt_idx_o]));

  assert_idle_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0 && (mode == PARK_NONE || mode == PARK_RSVD)) |=> !connected_o);

  assert_idle_last_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0 && mode == PARK_LAST) |=>
    (connected_o && gnt_idx_o == $past(last_q)));

  assert_idle_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0 && mode == PARK_FIXED && int'(cfg_fixed_i) < N) |=>
    (connected_o && gnt_idx_o == IW'($past(cfg_fixed_i))));

  assert_slot_break_R7: assert property (@(posedge clk) disable iff (rst)
    (connected_o && req_i[gnt_idx_o] && !burst_end_i[gnt_idx_o] && expired &&
     ((req_i & ~gnt_o) != '0)) |=> (gnt_idx_o != $past(gnt_idx_o)));

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (connected_o && req_i[gnt_idx_o] && !burst_end_i[gnt_idx_o] &&
     (cfg_limit_i == '0 || (req_i & ~gnt_o) == '0)) |=> $stable(gnt_o));
endmodule

// File: tb/slot_arb_test.sv
`timescale 1ns/1ps
module slot_arb_test;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] req = '0;
  logic [4:0] bend = '0;
  logic [7:0] lim = '0;
  logic [1:0] pol = '0;
  logic [2:0] fx = '0;
  logic [4:0] gnt;
  logic [2:0] gidx;
  logic       conn;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slot_arb #(.NUM_MASTERS(N)) uut (
    .clk(clk), .rst(rst), .req_i(req), .burst_end_i(bend),
    .cfg_limit_i(lim), .cfg_park_i(pol), .cfg_fixed_i(fx),
    .gnt_o(gnt), .gnt_idx_o(gidx), .connected_o(conn)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Encodes the whole visible state: -1 when disconnected, else the index.
  function automatic int seen();
    if (!conn && gnt == 5'b0) return -1;
    if (conn && gnt == (5'b1 << gidx)) return int'(gidx);
    return 99;
  endfunction

  function automatic int park_exp(input int p, input int f, input int lastm);
    if (p == 1) return lastm;
    if (p == 2 && f < N) return f;
    return -1;
  endfunction

  task automatic do_reset(input int l, input int p, input int f);
    lim = 8'(l); pol = 2'(p); fx = 3'(f);
    req = '0; bend = '0;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    // R1: state during reset
    do_reset(0, 1, 2);
    chk("R1 gnt in reset", int'(gnt), 0);
    chk("R1 conn in reset", int'(conn), 0);
    chk("R1 idx in reset", int'(gidx), 0);

    // R2 R3 R4 R5: every mode, fixed index and requesting master
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 8; f++) begin
        for (int m = 0; m < N; m++) begin
          int pt;
          do_reset(0, p, f);
          step();
          pt = park_exp(p, f, 0);
          chk($sformatf("R2/R3/R4 park after reset p%0d f%0d", p, f), seen(), pt);
          req = 5'(1 << m);
          chk($sformatf("R5 same-cycle grant p%0d f%0d m%0d", p, f, m),
              int'(gnt[m]), (pt == m) ? 1 : 0);
          step();
          chk($sformatf("R5 grant after request m%0d", m), seen(), m);
          bend = 5'(1 << m);
          step();
          req = '0; bend = '0;
          chk($sformatf("R2/R3/R4 park after burst p%0d f%0d m%0d", p, f, m),
              seen(), park_exp(p, f, m));
          step();
          chk($sformatf("R2/R3/R4 park holds p%0d f%0d m%0d", p, f, m),
              seen(), park_exp(p, f, m));
        end
      end
    end

    // R6: round-robin order from every starting owner
    for (int s = 0; s < N; s++) begin
      do_reset(0, 0, 7);
      step();
      req = 5'(1 << s);
      step();
      chk($sformatf("R6 start owner %0d", s), seen(), s);
      req = 5'b11111; bend = 5'b11111;
      for (int k = 0; k < 10; k++) begin
        step();
        chk($sformatf("R6 order from %0d step %0d", s, k), seen(), (s + 1 + k) % N);
      end
      req = '0; bend = '0;
    end

    // R7 R8: slot limit under contention and alone
    for (int l = 0; l < 6; l++) begin
      int n;
      do_reset(l, 0, 7);
      step();
      req = 5'b00010;
      step();
      chk($sformatf("R5 long burst owner L%0d", l), seen(), 1);
      req = 5'b01010;
      if (l == 0) begin
        for (int k = 0; k < 20; k++) begin
          step();
          chk($sformatf("R8 unlimited burst keeps grant k%0d", k), seen(), 1);
        end
      end else begin
        n = 0;
        while (seen() == 1 && n < 50) begin n++; step(); end
        chk($sformatf("R7 first owner cycles L%0d", l), n, l);
        chk($sformatf("R7 waiter takes over L%0d", l), seen(), 3);
        n = 0;
        while (seen() == 3 && n < 50) begin n++; step(); end
        chk($sformatf("R7 second owner cycles L%0d", l), n, l);
        chk($sformatf("R7 grant returns L%0d", l), seen(), 1);
        req = 5'b00010;
        for (int k = 0; k < 3 * l + 2; k++) begin
          step();
          chk($sformatf("R8 lone burst past limit L%0d k%0d", l, k), seen(), 1);
        end
      end
      req = '0;
    end

    // R9: grant shape seen at the ports across the runs above ends with idle state
    step();
    chk("R9 idle grant shape", int'(seen() != 99), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule